// File: doc/BRIEF.md
# Fuse Access Strobe Timing Sequencer

This block turns a single start request into the timed control waveform that a one-time-programmable fuse array needs for one access, either a read or a program. When a start arrives while the block is idle, it samples four cycle-count fields and the read/program select. It then steps through four phases:

- a setup relax interval;
- the active strobe;
- a hold relax interval;
- a recovery wait.

At the end it returns to idle and issues a one-cycle done pulse.

Each field holds its required cycle count minus one. The strobe fields describe the whole pulse, so a relax interval sits inside them at each edge. The active strobe is therefore the field plus one, less two relax intervals of relax+1 cycles each. If that result would be zero or negative, the active strobe is clamped to one cycle. A read uses the read-strobe field and a program uses the program-strobe field. The relax and wait fields are shared by both kinds of access.

A controller sets the fields from its clock frequency: at least 150 ns of recovery wait, at least 100 ns per relax interval, at least 40 ns of read strobe, and about 10 us of program strobe. It then pulses start and waits for done. The array enable is high for the setup, strobe and hold phases. The program enable is high across the same span, but only for a program access.

Top module: `fuse_strobe_seq`

## Requirements
- R1: While reset is low and after its release, busy_o, array_en_o, strobe_o, prog_en_o and done_o are all 0.
- R2: A start_i that is high at a clock edge while busy_o is low is accepted, and busy_o is 1 from the next cycle. busy_o then stays high for exactly 2*(relax+1) + A + (wait+1) cycles, where A is the active strobe length.
- R3: array_en_o is high for the first 2*(relax+1) + A cycles of busy_o. It is low for the last wait+1 cycles, which form the recovery phase.
- R4: strobe_o rises after exactly relax+1 cycles of array_en_o and stays high for A consecutive cycles. array_en_o then remains high for relax+1 more cycles.
- R5: With prog_sel_i = 0 the read-strobe field sets A and prog_en_o stays 0 throughout. With prog_sel_i = 1 the program-strobe field sets A and prog_en_o is high exactly while array_en_o is high.
- R6: A = S+1-2*(relax+1) when that value is at least 1, where S is the selected strobe field; otherwise A = 1.
- R7: All fields and prog_sel_i are sampled only at the accepting edge. Changing them during an operation does not alter that operation's waveform.
- R8: A start_i that is high while busy_o is high is ignored. The operation's length is unchanged, no second operation follows, and only one done pulse is produced.
- R9: done_o is high for exactly one cycle, namely the first cycle after busy_o falls, and busy_o is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one access; honoured only when idle |
| prog_sel_i | input | 1 | 1 = program access, 0 = read access |
| wait_cyc_i | input | CNT_W | Recovery wait length minus one |
| relax_cyc_i | input | CNT_W | Length of each relax interval minus one |
| rd_strobe_i | input | CNT_W | Whole read strobe, both relax edges included, minus one |
| pg_strobe_i | input | CNT_W | Whole program strobe, both relax edges included, minus one |
| busy_o | output | 1 | Operation in progress |
| array_en_o | output | 1 | Fuse array enable (setup, strobe, hold) |
| strobe_o | output | 1 | Active strobe window |
| prog_en_o | output | 1 | Program enable (program access only) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the strobe clamp: fields that are smaller than, equal to, and just above the two relax intervals. A design that subtracted without clamping would wrap round to an enormous strobe, or emit no strobe at all.

Relax values of zero exercise off-by-one errors in the phase counters. Such an error shows up as a setup, strobe or wait phase one cycle too long or too short.

Fields are changed in the middle of an operation. A design that read them live instead of latching them would stretch or shorten the current waveform.

A second start is sent while busy. A design that honoured it would restart or lengthen the operation, or emit two done pulses.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_RECOV = 3'd4
  } phase_e;

  // Active strobe length minus one for a whole-pulse field and a relax field.
  // The whole pulse is field+1 cycles; two relax intervals of relax+1 come out.
  // Result clamps to 0 (one active cycle) when nothing would be left.
  function automatic longint unsigned pulse_len_m1(longint unsigned strobe_f,
                                                   longint unsigned relax_f);
    longint unsigned whole;
    longint unsigned edges;
    whole = strobe_f + 64'd1;
    edges = 64'd2 * (relax_f + 64'd1);
    return (whole > edges) ? (whole - edges - 64'd1) : 64'd0;
  endfunction

endpackage

// File: rtl/fuse_timing_latch.sv
module fuse_timing_latch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_i,
  input  logic             prog_sel_i,
  input  logic [CNT_W-1:0] wait_cyc_i,
  input  logic [CNT_W-1:0] relax_cyc_i,
  input  logic [CNT_W-1:0] rd_strobe_i,
  input  logic [CNT_W-1:0] pg_strobe_i,
  output logic [CNT_W-1:0] relax_q,
  output logic [CNT_W-1:0] pulse_q,
  output logic [CNT_W-1:0] wait_q,
  output logic             prog_q
);
  import fuse_seq_pkg::*;

  logic [CNT_W-1:0] sel_strobe;
  logic [CNT_W-1:0] pulse_m1;

  assign sel_strobe = prog_sel_i ? pg_strobe_i : rd_strobe_i;
  assign pulse_m1   = CNT_W'(pulse_len_m1(64'(sel_strobe), 64'(relax_cyc_i)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      relax_q <= '0;
      pulse_q <= '0;
      wait_q  <= '0;
      prog_q  <= 1'b0;
    end else if (capture_i) begin
      relax_q <= relax_cyc_i;
      pulse_q <= pulse_m1;
      wait_q  <= wait_cyc_i;
      prog_q  <= prog_sel_i;
    end
  end

endmodule

// File: rtl/fuse_phase_fsm.sv
module fuse_phase_fsm #(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [CNT_W-1:0]      setup_ld_i,
  input  logic [CNT_W-1:0]      relax_i,
  input  logic [CNT_W-1:0]      pulse_i,
  input  logic [CNT_W-1:0]      wait_i,
  output fuse_seq_pkg::phase_e  phase_o,
  output logic                  accept_o,
  output logic                  phase_end_o,
  output logic                  done_o
);
  import fuse_seq_pkg::*;

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o    = start_i && (phase_q == PH_IDLE);
  assign phase_end_o = (phase_q != PH_IDLE) && (cnt_q == '0);
  assign phase_o     = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= phase_end_o && (phase_q == PH_RECOV);
      if (accept_o) begin
        phase_q <= PH_SETUP;
        cnt_q   <= setup_ld_i;
      end else if (phase_end_o) begin
        unique case (phase_q)
          PH_SETUP: begin phase_q <= PH_PULSE; cnt_q <= pulse_i; end
          PH_PULSE: begin phase_q <= PH_HOLD;  cnt_q <= relax_i; end
          PH_HOLD:  begin phase_q <= PH_RECOV; cnt_q <= wait_i;  end
          default:  begin phase_q <= PH_IDLE;  cnt_q <= '0;      end
        endcase
      end else if (phase_q != PH_IDLE) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/fuse_pin_decode.sv
module fuse_pin_decode (
  input  fuse_seq_pkg::phase_e phase_i,
  input  logic                 prog_i,
  output logic                 busy_o,
  output logic                 array_en_o,
  output logic                 strobe_o,
  output logic                 prog_en_o
);
  import fuse_seq_pkg::*;

  always_comb begin
    busy_o     = (phase_i != PH_IDLE);
    array_en_o = (phase_i == PH_SETUP) || (phase_i == PH_PULSE) || (phase_i == PH_HOLD);
    strobe_o   = (phase_i == PH_PULSE);
    prog_en_o  = array_en_o && prog_i;
  end

endmodule

// File: rtl/fuse_strobe_seq.sv
module fuse_strobe_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             prog_sel_i,
  input  logic [CNT_W-1:0] wait_cyc_i,
  input  logic [CNT_W-1:0] relax_cyc_i,
  input  logic [CNT_W-1:0] rd_strobe_i,
  input  logic [CNT_W-1:0] pg_strobe_i,
  output logic             busy_o,
  output logic             array_en_o,
  output logic             strobe_o,
  output logic             prog_en_o,
  output logic             done_o
);
  import fuse_seq_pkg::*;

  logic [CNT_W-1:0] relax_w, pulse_w, wait_w;
  logic             prog_w;
  logic             accept_w;
  logic             phase_end_w;
  phase_e           phase_w;

  fuse_timing_latch #(.CNT_W(CNT_W)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture_i   (accept_w),
    .prog_sel_i  (prog_sel_i),
    .wait_cyc_i  (wait_cyc_i),
    .relax_cyc_i (relax_cyc_i),
    .rd_strobe_i (rd_strobe_i),
    .pg_strobe_i (pg_strobe_i),
    .relax_q     (relax_w),
    .pulse_q     (pulse_w),
    .wait_q      (wait_w),
    .prog_q      (prog_w)
  );

  fuse_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .setup_ld_i  (relax_cyc_i),
    .relax_i     (relax_w),
    .pulse_i     (pulse_w),
    .wait_i      (wait_w),
    .phase_o     (phase_w),
    .accept_o    (accept_w),
    .phase_end_o (phase_end_w),
    .done_o      (done_o)
  );

  fuse_pin_decode u_dec (
    .phase_i    (phase_w),
    .prog_i     (prog_w),
    .busy_o     (busy_o),
    .array_en_o (array_en_o),
    .strobe_o   (strobe_o),
    .prog_en_o  (prog_en_o)
  );

endmodule

// File: rtl/fuse_strobe_seq_chk.sv
module fuse_strobe_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic array_en_o,
  input logic strobe_o,
  input logic prog_en_o,
  input logic done_o,
  input logic accept_w,
  input logic phase_end_w
);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |-> !accept_w);

  // R3
  array_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    array_en_o |-> busy_o);

  // R4
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> $past(array_en_o));

  // R4
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> array_en_o);

  // R5
  prog_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en_o |-> array_en_o);

  // R7
  prog_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    array_en_o && $past(array_en_o) |-> $stable(prog_en_o));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && $past(busy_o) && $past(phase_end_w));

endmodule

bind fuse_strobe_seq fuse_strobe_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .array_en_o  (array_en_o),
  .strobe_o    (strobe_o),
  .prog_en_o   (prog_en_o),
  .done_o      (done_o),
  .accept_w    (accept_w),
  .phase_end_w (phase_end_w)
);

// File: tb/test_fuse_strobe_seq.sv
module test_fuse_strobe_seq;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic prog_sel_i = 1'b0;
  logic [CNT_W-1:0] wait_cyc_i = '0, relax_cyc_i = '0, rd_strobe_i = '0, pg_strobe_i = '0;
  logic busy_o, array_en_o, strobe_o, prog_en_o, done_o;

  always #2 clk = ~clk;

  fuse_strobe_seq #(.CNT_W(CNT_W)) i_fuse_strobe_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .prog_sel_i(prog_sel_i),
    .wait_cyc_i(wait_cyc_i), .relax_cyc_i(relax_cyc_i),
    .rd_strobe_i(rd_strobe_i), .pg_strobe_i(pg_strobe_i),
    .busy_o(busy_o), .array_en_o(array_en_o), .strobe_o(strobe_o),
    .prog_en_o(prog_en_o), .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;

  // prog, wait, relax, read strobe, program strobe | expected setup, active, recovery
  typedef struct packed {
    logic       prog;
    logic [7:0] w, r, rd, pg;
    logic [7:0] e_pre, e_act, e_wait;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 8'd2, 8'd1, 8'd7,  8'd30, 8'd2, 8'd4,  8'd3},
    '{1'b1, 8'd0, 8'd0, 8'd5,  8'd9,  8'd1, 8'd8,  8'd1},
    '{1'b0, 8'd5, 8'd3, 8'd3,  8'd40, 8'd4, 8'd1,  8'd6},
    '{1'b1, 8'd1, 8'd2, 8'd50, 8'd5,  8'd3, 8'd1,  8'd2},
    '{1'b0, 8'd0, 8'd0, 8'd2,  8'd2,  8'd1, 8'd1,  8'd1},
    '{1'b1, 8'd3, 8'd4, 8'd1,  8'd20, 8'd5, 8'd11, 8'd4}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one operation; mode 1 changes fields mid-run, mode 2 pulses start mid-run.
  task automatic run_op(input vec_t v, input int mode);
    int n_busy = 0, n_arr = 0, n_str = 0, n_prog = 0, first_str = -1, n_done = 0;
    int e_arr, e_busy;
    e_arr  = 2 * int'(v.e_pre) + int'(v.e_act);
    e_busy = e_arr + int'(v.e_wait);
    @(negedge clk);
    prog_sel_i  = v.prog;
    wait_cyc_i  = CNT_W'(v.w);
    relax_cyc_i = CNT_W'(v.r);
    rd_strobe_i = CNT_W'(v.rd);
    pg_strobe_i = CNT_W'(v.pg);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o && n_busy < 1000) begin
      if (array_en_o) n_arr++;
      if (strobe_o) begin
        if (first_str < 0) first_str = n_busy;
        n_str++;
      end
      if (prog_en_o) n_prog++;
      if (done_o) n_done++;
      if (mode == 1 && n_busy == 0) begin
        prog_sel_i = ~v.prog; wait_cyc_i = 16'd9; relax_cyc_i = 16'd7;
        rd_strobe_i = 16'd60; pg_strobe_i = 16'd60;
      end
      if (mode == 2) start_i = (n_busy == 1) || (n_busy == e_busy - 1);
      n_busy++;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(n_busy == e_busy, "R2 busy length", n_busy, e_busy);
    check(n_arr == e_arr, "R3 array enable length", n_arr, e_arr);
    check(first_str == int'(v.e_pre), "R4 strobe start", first_str, int'(v.e_pre));
    check(n_str == int'(v.e_act), "R4 R6 strobe length", n_str, int'(v.e_act));
    check(n_prog == (v.prog ? e_arr : 0), "R5 program enable", n_prog, v.prog ? e_arr : 0);
    check(done_o == 1'b1 && n_done == 0, "R9 done on first idle cycle", int'(done_o), 1);
    @(negedge clk);
    check(done_o == 1'b0 && busy_o == 1'b0, "R9 R8 single done, no restart",
          int'(done_o) + int'(busy_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    // R1: outputs idle during reset, even with start high
    check({busy_o, array_en_o, strobe_o, prog_en_o, done_o} == 5'b0, "R1 in reset",
          int'({busy_o, array_en_o, strobe_o, prog_en_o, done_o}), 0);
    start_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check({busy_o, array_en_o, strobe_o, prog_en_o, done_o} == 5'b0, "R1 after release",
          int'({busy_o, array_en_o, strobe_o, prog_en_o, done_o}), 0);

    for (int i = 0; i < 6; i++) run_op(VECS[i], 0);

    // R7: fields and select changed one cycle into the operation
    run_op(VECS[0], 1);
    run_op(VECS[5], 1);
    // R8: start raised while busy, including the final busy cycle
    run_op(VECS[1], 2);
    run_op(VECS[2], 2);

    repeat (3) @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R8 stays idle", int'(busy_o), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule